// File: doc/BRIEF.md
# Turbo Decoder Iteration Sequencer

This block sequences an iterative two-stage soft decoder. After the input buffer has been loaded with the systematic and parity samples, one pulse on `blk_start` begins a decode. The sequencer then hands control back and forth between the two soft-in soft-out units. It sends each unit a one-cycle start pulse and waits for that unit's done flag before it moves on. While each unit works, it also drives the routing selects that say which permutation path feeds that unit.

The first unit works first in every full iteration. From the second iteration on, it receives the second unit's extrinsic values through the deinterleaver. The second unit always receives the first unit's output through the interleaver. When the programmed number of full iterations has been run, the sequencer opens the final readout. The deinterleaver then streams the final log-likelihood values into the sequencer, which turns each one into a hard bit by its sign. It emits one bit per accepted sample, marks the last bit of the block, and drops `busy` once that last bit has been shown.

Top module: `turbo_iter_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, all outputs go to zero after that edge: `busy`, both start pulses, the three selects and the bit outputs.
- R2: A `blk_start` sampled while idle makes `siso1_start` high for exactly one cycle, starting on the next cycle, and `busy` goes high in that same cycle.
- R3: `siso2_start` is a one-cycle pulse. It appears exactly one cycle after a `siso1_done` that was sampled while the sequencer waited for the first unit, and at no other time.
- R4: A `siso2_done` sampled while waiting for the second unit starts the next iteration when iterations remain: `siso1_start` pulses on the following cycle.
- R5: A done flag sampled when the sequencer is not waiting for that unit has no effect. This covers done flags in the start-pulse cycle, done flags for the other unit, and done flags while idle.
- R6: Only one of the three selects is high at a time. `fwd_sel` (interleaver feeds unit 2) is high from `siso2_start` until the second unit's done is taken. `back_sel` (deinterleaver feeds unit 1) is high during the first unit's phase in every iteration except the first. `drain_sel` is high while the final values are read out.
- R7: `iter_limit` is captured at block start. Each unit is started exactly that many times, and a value of 0 counts as 1. After the last `siso2_done`, `drain_sel` rises on the next cycle and no further start pulse is sent.
- R8: Each `llr_vld` sampled while `drain_sel` is high gives `bit_vld` on the next cycle. `llr_in` is two's complement: a negative value gives `bit_out` = 1, and zero or a positive value gives 0.
- R9: `bit_last` is high together with the BLK_LEN-th bit of the block. `busy` is still high in that cycle and goes low on the following cycle.
- R10: `blk_start` is ignored while `busy` is high. `llr_vld` is ignored when `drain_sel` is low, so no bit is emitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| blk_start | input | 1 | Begin decoding the buffered block |
| iter_limit | input | ITER_W | Full iterations to run (0 treated as 1) |
| siso1_start | output | 1 | Start pulse to the first unit |
| siso1_done | input | 1 | First unit finished its half-iteration |
| siso2_start | output | 1 | Start pulse to the second unit |
| siso2_done | input | 1 | Second unit finished its half-iteration |
| fwd_sel | output | 1 | Route the first unit's output through the interleaver to the second unit |
| back_sel | output | 1 | Route the second unit's output through the deinterleaver to the first unit |
| drain_sel | output | 1 | Final readout from the deinterleaver is open |
| llr_in | input | LLR_W | Final soft value, two's complement |
| llr_vld | input | 1 | `llr_in` is valid |
| bit_out | output | 1 | Hard-decided bit |
| bit_vld | output | 1 | `bit_out` is valid |
| bit_last | output | 1 | Last bit of the block |
| busy | output | 1 | A decode is in progress |

## Verification
The unit models answer with latencies that change from one start to the next. Short latencies exercise a done that arrives on the first waiting cycle. Longer ones exercise waits of several cycles, and together they separate a sequencer that truly waits from one that just counts cycles. Iteration limits of 0, 1, 2, 3 and 15 separate correct limit handling from off-by-one errors and from a zero limit that is not treated as one.

Some runs inject stray done flags for the unit that is not being waited on, and others assert `blk_start` and `llr_vld` at times when they must be ignored. These runs expose state decoding that listens too widely. The final soft stream contains the values 0, -1, the most negative value and the most positive value, both back to back and with idle gaps. This shows whether the sign is taken from the correct bit and whether the last-bit marking follows the count of accepted samples rather than the count of cycles.

// File: rtl/turbo_ctrl_pkg.sv
// Package: shared types for the turbo iteration sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package turbo_ctrl_pkg;

    // Sequencer phases; each unit gets a one-cycle kick state and a wait state.
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_U1_KICK = 3'd1,
        ST_U1_WAIT = 3'd2,
        ST_U2_KICK = 3'd3,
        ST_U2_WAIT = 3'd4,
        ST_DRAIN   = 3'd5,
        ST_FLUSH   = 3'd6
    } seq_state_t;

    // Number of soft-in soft-out units handled by the sequencer.
    localparam int NUM_UNITS = 2;

endpackage

// File: rtl/tdc_iter_count.sv
// Module: tdc_iter_count
// Does: captures the iteration limit at block start (0 becomes 1) and counts
//       half iterations (one per accepted done) and full iterations.
// Assumes: load_i and half_step_i are never high together; half_step_i comes
//          only from accepted done flags.
module tdc_iter_count #(
    parameter int ITER_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [ITER_W-1:0] limit_i,
    input  logic              half_step_i,
    output logic              first_iter_o,
    output logic              final_iter_o
);

    localparam logic [ITER_W-1:0] ONE = ITER_W'(1);

    logic [ITER_W-1:0] lim_q;
    logic [ITER_W-1:0] full_q;
    logic              half_q;

    // Capture the limit, then advance the half/full iteration counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lim_q  <= ONE;
            full_q <= '0;
            half_q <= 1'b0;
        end else if (load_i) begin
            lim_q  <= (limit_i == '0) ? ONE : limit_i;
            full_q <= '0;
            half_q <= 1'b0;
        end else if (half_step_i) begin
            half_q <= ~half_q;
            if (half_q) begin
                full_q <= full_q + ONE;
            end
        end
    end

    // Flag the first iteration and the one that must end the decode.
    always_comb begin
        first_iter_o = (full_q == '0);
        final_iter_o = (full_q == (lim_q - ONE));
    end

endmodule

// File: rtl/tdc_seq_fsm.sv
// Module: tdc_seq_fsm
// Does: holds the sequencer phase and moves it on block start, on the done
//       flag of the unit currently being waited on, and at the end of readout.
// Assumes: done flags are sampled only in the matching wait state; all other
//          done flags are dropped here.
module tdc_seq_fsm
    import turbo_ctrl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       blk_start_i,
    input  logic       u1_done_i,
    input  logic       u2_done_i,
    input  logic       final_iter_i,
    input  logic       last_take_i,
    output seq_state_t state_o,
    output logic       accept_o,
    output logic       half_step_o
);

    seq_state_t state_q;
    seq_state_t state_d;

    // Compute the next phase from the current phase and the qualified events.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (blk_start_i)  state_d = ST_U1_KICK;
            ST_U1_KICK: state_d = ST_U1_WAIT;
            ST_U1_WAIT: if (u1_done_i)    state_d = ST_U2_KICK;
            ST_U2_KICK: state_d = ST_U2_WAIT;
            ST_U2_WAIT: if (u2_done_i)    state_d = final_iter_i ? ST_DRAIN : ST_U1_KICK;
            ST_DRAIN:   if (last_take_i)  state_d = ST_FLUSH;
            ST_FLUSH:   state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // Register the phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Report the accepted block start and each accepted done.
    always_comb begin
        state_o     = state_q;
        accept_o    = (state_q == ST_IDLE) && blk_start_i;
        half_step_o = ((state_q == ST_U1_WAIT) && u1_done_i) ||
                      ((state_q == ST_U2_WAIT) && u2_done_i);
    end

endmodule

// File: rtl/tdc_slicer.sv
// Module: tdc_slicer
// Does: takes final soft values while readout is open, decides each bit by
//       its sign, and marks the BLK_LEN-th bit as last.
// Assumes: soft values are two's complement; clear_i comes before each block.
module tdc_slicer #(
    parameter int LLR_W   = 8,
    parameter int BLK_LEN = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             drain_i,
    input  logic [LLR_W-1:0] llr_i,
    input  logic             llr_vld_i,
    output logic             last_take_o,
    output logic             bit_o,
    output logic             bit_vld_o,
    output logic             bit_last_o
);

    localparam int            CNT_W   = $clog2(BLK_LEN + 1);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(BLK_LEN - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             take;

    // Qualify a sample and detect the one that closes the block.
    always_comb begin
        take        = drain_i && llr_vld_i;
        last_take_o = take && (cnt_q == LAST_IDX);
    end

    // Count accepted samples within the block.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear_i) begin
            cnt_q <= '0;
        end else if (take) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    // Register the sign decision with its strobe and last-bit flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_o      <= 1'b0;
            bit_vld_o  <= 1'b0;
            bit_last_o <= 1'b0;
        end else begin
            bit_o      <= take ? llr_i[LLR_W-1] : 1'b0;
            bit_vld_o  <= take;
            bit_last_o <= last_take_o;
        end
    end

endmodule

// File: rtl/turbo_iter_ctrl.sv
// Module: turbo_iter_ctrl (top)
// Does: alternates start/done handshakes between two soft-in soft-out units,
//       drives the interleave/deinterleave routing selects, runs a programmable
//       number of full iterations, then hard-decides the final soft stream.
// Assumes: the input buffer is loaded before blk_start; the units raise done
//          only after their start pulse; the deinterleaver streams the final
//          values while drain_sel is high.
module turbo_iter_ctrl
    import turbo_ctrl_pkg::*;
#(
    parameter int LLR_W   = 8,
    parameter int ITER_W  = 4,
    parameter int BLK_LEN = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              blk_start,
    input  logic [ITER_W-1:0] iter_limit,
    output logic              siso1_start,
    input  logic              siso1_done,
    output logic              siso2_start,
    input  logic              siso2_done,
    output logic              fwd_sel,
    output logic              back_sel,
    output logic              drain_sel,
    input  logic [LLR_W-1:0]  llr_in,
    input  logic              llr_vld,
    output logic              bit_out,
    output logic              bit_vld,
    output logic              bit_last,
    output logic              busy
);

    seq_state_t            state;
    logic                  accept;
    logic                  half_step;
    logic                  first_iter;
    logic                  final_iter;
    logic                  last_take;
    logic [NUM_UNITS-1:0]  kick_vec;
    logic [NUM_UNITS-1:0]  phase_vec;

    // Phase sequencing.
    tdc_seq_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .blk_start_i  (blk_start),
        .u1_done_i    (siso1_done),
        .u2_done_i    (siso2_done),
        .final_iter_i (final_iter),
        .last_take_i  (last_take),
        .state_o      (state),
        .accept_o     (accept),
        .half_step_o  (half_step)
    );

    // Iteration limit and counters.
    tdc_iter_count #(.ITER_W(ITER_W)) u_cnt (
        .clk          (clk),
        .rst_n        (rst_n),
        .load_i       (accept),
        .limit_i      (iter_limit),
        .half_step_i  (half_step),
        .first_iter_o (first_iter),
        .final_iter_o (final_iter)
    );

    // Final readout and sign slicing.
    tdc_slicer #(.LLR_W(LLR_W), .BLK_LEN(BLK_LEN)) u_slc (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear_i     (accept),
        .drain_i     (drain_sel),
        .llr_i       (llr_in),
        .llr_vld_i   (llr_vld),
        .last_take_o (last_take),
        .bit_o       (bit_out),
        .bit_vld_o   (bit_vld),
        .bit_last_o  (bit_last)
    );

    // Per-unit kick and phase decode; unit g owns kick state 1+2g and wait state 2+2g.
    for (genvar g = 0; g < NUM_UNITS; g++) begin : g_unit
        localparam seq_state_t KICK_ST = seq_state_t'(3'(1 + 2 * g));
        localparam seq_state_t WAIT_ST = seq_state_t'(3'(2 + 2 * g));
        always_comb begin
            kick_vec[g]  = (state == KICK_ST);
            phase_vec[g] = (state == KICK_ST) || (state == WAIT_ST);
        end
    end

    // Drive handshakes, routing selects and busy from the phase.
    always_comb begin
        siso1_start = kick_vec[0];
        siso2_start = kick_vec[1];
        fwd_sel     = phase_vec[1];
        back_sel    = phase_vec[0] && !first_iter;
        drain_sel   = (state == ST_DRAIN);
        busy        = (state != ST_IDLE);
    end

endmodule

// File: rtl/turbo_iter_ctrl_chk.sv
// Module: turbo_iter_ctrl_chk
// Does: port-level temporal checks for turbo_iter_ctrl, attached by bind.
// Assumes: the same parameters as the block it checks.
module turbo_iter_ctrl_chk #(
    parameter int LLR_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             blk_start,
    input logic             siso1_start,
    input logic             siso1_done,
    input logic             siso2_start,
    input logic             siso2_done,
    input logic             fwd_sel,
    input logic             back_sel,
    input logic             drain_sel,
    input logic [LLR_W-1:0] llr_in,
    input logic             llr_vld,
    input logic             bit_out,
    input logic             bit_vld,
    input logic             bit_last,
    input logic             busy
);

    p_start1_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        siso1_start |=> !siso1_start);

    p_start2_after_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
        siso2_start |-> $past(siso1_done));

    p_start2_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        siso2_start |=> !siso2_start);

    p_idle_done_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !blk_start && (siso1_done || siso2_done)) |=> !busy);

    p_one_path_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({fwd_sel, back_sel, drain_sel}) <= 1);

    p_fwd_on_start2_r6: assert property (@(posedge clk) disable iff (!rst_n)
        siso2_start |-> fwd_sel);

    p_sign_slice_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bit_vld |-> (bit_out == $past(llr_in[LLR_W-1])));

    p_last_then_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_vld && bit_last) |=> !busy);

    p_bit_while_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bit_vld |-> busy);

    p_restart_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && blk_start && !siso2_done) |=> !siso1_start);

    p_vld_needs_drain_r10: assert property (@(posedge clk) disable iff (!rst_n)
        bit_vld |-> $past(drain_sel && llr_vld));

endmodule

bind turbo_iter_ctrl turbo_iter_ctrl_chk #(.LLR_W(LLR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .blk_start   (blk_start),
    .siso1_start (siso1_start),
    .siso1_done  (siso1_done),
    .siso2_start (siso2_start),
    .siso2_done  (siso2_done),
    .fwd_sel     (fwd_sel),
    .back_sel    (back_sel),
    .drain_sel   (drain_sel),
    .llr_in      (llr_in),
    .llr_vld     (llr_vld),
    .bit_out     (bit_out),
    .bit_vld     (bit_vld),
    .bit_last    (bit_last),
    .busy        (busy)
);

// File: tb/sim_turbo_iter_ctrl.sv
// Bench: scoreboard for turbo_iter_ctrl. The driver pushes expected bits into
// a queue; one negedge process models both units, checks the handshakes and
// pops and compares the bits the design emits.
module sim_turbo_iter_ctrl;

    localparam int LLR_W   = 8;
    localparam int ITER_W  = 4;
    localparam int BLK_LEN = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              blk_start = 1'b0;
    logic [ITER_W-1:0] iter_limit = '0;
    logic              siso1_start;
    logic              siso1_done = 1'b0;
    logic              siso2_start;
    logic              siso2_done = 1'b0;
    logic              fwd_sel;
    logic              back_sel;
    logic              drain_sel;
    logic [LLR_W-1:0]  llr_in = '0;
    logic              llr_vld = 1'b0;
    logic              bit_out;
    logic              bit_vld;
    logic              bit_last;
    logic              busy;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    // Scoreboard and unit-model state.
    logic [1:0] exp_q[$];
    int  cur_eff = 1;
    int  lat1 = 1, lat2 = 1;
    bit  inject = 0;
    bit  stray_req = 0;
    int  n_s1 = 0, n_s2 = 0, n_d2 = 0;
    int  cnt1 = 0, cnt2 = 0, pend1 = 0, pend2 = 0;
    bit  d1_legit = 0, d2_legit = 0;
    bit  last_prev = 0;

    always #10 clk = ~clk;   // 50 MHz

    turbo_iter_ctrl #(.LLR_W(LLR_W), .ITER_W(ITER_W), .BLK_LEN(BLK_LEN)) u0 (
        .clk(clk), .rst_n(rst_n), .blk_start(blk_start), .iter_limit(iter_limit),
        .siso1_start(siso1_start), .siso1_done(siso1_done),
        .siso2_start(siso2_start), .siso2_done(siso2_done),
        .fwd_sel(fwd_sel), .back_sel(back_sel), .drain_sel(drain_sel),
        .llr_in(llr_in), .llr_vld(llr_vld),
        .bit_out(bit_out), .bit_vld(bit_vld), .bit_last(bit_last), .busy(busy)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [LLR_W-1:0] llr_at(input int i, input int seed);
        case (i % 8)
            0: return '0;
            1: return '1;
            2: return {1'b1, {(LLR_W-1){1'b0}}};
            3: return {1'b0, {(LLR_W-1){1'b1}}};
            default: return LLR_W'((i * 53 + seed * 29) ^ (i << 2));
        endcase
    endfunction

    // Monitor and unit model: check with the done values the last edge saw, then update.
    initial begin
        wait (rst_n);
        forever begin
            @(negedge clk);
            if (siso1_done && d1_legit) chk(siso2_start, "R3 start2 after done1", siso2_start, 1);
            if (siso2_start) chk(siso1_done && d1_legit, "R3 start2 without done1", siso1_done, 1);
            if (siso2_done && d2_legit) begin
                n_d2++;
                if (n_d2 < cur_eff) chk(siso1_start, "R4 next iteration", siso1_start, 1);
                else chk(drain_sel && !siso1_start, "R7 readout after last iteration", drain_sel, 1);
            end
            if ((siso1_done && !d1_legit) || (siso2_done && !d2_legit))
                chk(!siso1_start && !siso2_start, "R5 stray done ignored",
                    int'(siso1_start) + int'(siso2_start), 0);
            chk($countones({fwd_sel, back_sel, drain_sel}) <= 1, "R6 selects exclusive",
                $countones({fwd_sel, back_sel, drain_sel}), 1);
            if (siso1_start) begin
                chk(!fwd_sel && !drain_sel && (back_sel == (n_s1 != 0)), "R6 select at start1",
                    int'(back_sel), int'(n_s1 != 0));
                n_s1++;
                cnt1 = lat1 + (n_s1 % 2) + 1;
                if (inject) pend2 = 2;
            end
            if (siso2_start) begin
                chk(fwd_sel && !back_sel && !drain_sel, "R6 select at start2", int'(fwd_sel), 1);
                n_s2++;
                cnt2 = lat2 + (n_s2 % 3) + 1;
                if (inject) pend1 = 2;
            end
            if (last_prev) chk(!busy, "R9 busy falls after last", busy, 0);
            if (bit_vld) begin
                if (exp_q.size() == 0) begin
                    chk(0, "R10 bit without readout sample", 1, 0);
                end else begin
                    logic [1:0] e;
                    e = exp_q.pop_front();
                    chk(bit_out == e[0], "R8 sign decision", bit_out, e[0]);
                    chk(bit_last == e[1], "R9 last flag", bit_last, e[1]);
                end
            end
            last_prev = bit_vld && bit_last;
            if (last_prev) chk(busy, "R9 busy during last", busy, 1);
            // Unit model update.
            siso1_done = 1'b0; siso2_done = 1'b0; d1_legit = 0; d2_legit = 0;
            if (cnt1 > 0) begin
                cnt1--;
                if (cnt1 == 0) begin siso1_done = 1'b1; d1_legit = 1; end
            end
            if (cnt2 > 0) begin
                cnt2--;
                if (cnt2 == 0) begin
                    chk(fwd_sel, "R6 fwd held while unit 2 works", fwd_sel, 1);
                    siso2_done = 1'b1; d2_legit = 1;
                end
            end
            if (pend1 > 0) begin
                pend1--;
                if (pend1 == 0 && !siso1_done) siso1_done = 1'b1;
            end
            if (pend2 > 0) begin
                pend2--;
                if (pend2 == 0 && !siso2_done) siso2_done = 1'b1;
            end
            if (stray_req) begin
                siso1_done = 1'b1; siso2_done = 1'b1; stray_req = 0;
            end
        end
    end

    // Driver: run one block and push the expected bits.
    task automatic run_block(input int lim, input int l1, input int l2,
                             input bit inj, input bit gaps, input int seed);
        cur_eff = (lim == 0) ? 1 : lim;
        lat1 = l1; lat2 = l2; inject = inj;
        n_s1 = 0; n_s2 = 0; n_d2 = 0;
        iter_limit = ITER_W'(lim);
        blk_start = 1'b1;
        @(negedge clk);
        blk_start = 1'b0;
        iter_limit = ITER_W'(lim + 5);
        chk(siso1_start && busy, "R2 start1 and busy after block start",
            int'(siso1_start) + int'(busy), 2);
        blk_start = 1'b1;
        llr_vld = 1'b1;
        llr_in = {1'b1, {(LLR_W-1){1'b0}}};
        @(negedge clk);
        blk_start = 1'b0;
        llr_vld = 1'b0;
        chk(!siso1_start, "R2 start1 single pulse", siso1_start, 0);
        @(negedge clk);
        chk(!bit_vld && !siso1_start, "R10 restart and early sample ignored",
            int'(bit_vld) + int'(siso1_start), 0);
        while (!drain_sel) @(negedge clk);
        chk(n_s1 == cur_eff, "R7 unit 1 start count", n_s1, cur_eff);
        chk(n_s2 == cur_eff, "R7 unit 2 start count", n_s2, cur_eff);
        for (int i = 0; i < BLK_LEN; i++) begin
            logic [LLR_W-1:0] v;
            if (gaps && (i % 3 == 2)) begin
                llr_vld = 1'b0;
                @(negedge clk);
            end
            v = llr_at(i, seed);
            llr_in = v;
            llr_vld = 1'b1;
            exp_q.push_back({(i == BLK_LEN - 1), v[LLR_W-1]});
            @(negedge clk);
        end
        llr_vld = 1'b0;
        while (busy) @(negedge clk);
        chk(exp_q.size() == 0, "R9 all bits emitted", exp_q.size(), 0);
        repeat (2) @(negedge clk);
    endtask

    // Main sequence.
    initial begin
        repeat (3) @(negedge clk);
        chk(!busy && !siso1_start && !siso2_start && !bit_vld && !bit_last && !bit_out,
            "R1 reset outputs", int'(busy) + int'(bit_vld), 0);
        chk(!fwd_sel && !back_sel && !drain_sel, "R1 reset selects",
            int'(fwd_sel) + int'(back_sel) + int'(drain_sel), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        stray_req = 1;
        repeat (3) @(negedge clk);
        chk(!busy, "R5 done while idle ignored", busy, 0);
        run_block(1, 1, 1, 0, 0, 1);
        run_block(3, 2, 4, 0, 1, 2);
        run_block(0, 1, 2, 0, 0, 3);
        run_block(2, 3, 3, 1, 1, 4);
        run_block(15, 1, 2, 0, 0, 5);
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule